// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from a set of sources into a sticky raw status register. It combines that register with an enable mask into a pending view and drives one level-sensitive interrupt line. Software reaches it through a plain register port that has a write strobe, an address, write data and combinational read data.

The enable mask has two write addresses: one that turns bits on and one that turns bits off. Each write touches only the bits written as 1, so no read-modify-write sequence is needed. A handler reads the pending view to find out which sources need service. If the pending view reads zero, this block did not raise the interrupt. The handler then writes ones to the same address to acknowledge those sources. Source 1 is the word-complete event of the serial engine next to this block.

Top module: `irqc_top`

## Requirements
- R1: After reset, the raw status and the enable mask are all zero, and `irq_out` is low.
- R2: A 1 on `evt_in[i]` at a clock edge sets raw status bit i, whatever the state of the enable mask. Reading offset 0x20 returns the raw status, zero-extended.
- R3: Reading offset 0x24 returns the bitwise AND of the raw status and the enable mask, so it reads zero when no pending source is enabled.
- R4: Writing 1 to bit i at offset 0x28 sets enable bit i, and writing 1 to bit i at offset 0x2C clears it. Bits written as 0 leave the mask unchanged. Reads of 0x28 and of 0x2C both return the enable mask.
- R5: Writing 1 to bit i at offset 0x24 clears raw status bit i. Bits written as 0 leave the status unchanged.
- R6: `irq_out` is high exactly while at least one raw status bit is pending with its enable bit set. It stays high until every such bit has been cleared or masked.
- R7: If an event pulse and a 1 written at offset 0x24 hit the same bit in the same cycle, the bit remains set.
- R8: Writes to offset 0x20 change nothing. Reads of any offset other than the four listed return zero.
- R9: The word-complete source drives `evt_in[1]`, and it uses bit 1 of the raw, pending, enable-set and enable-clear registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| evt_in | input | NUM_SRC | One event pulse per source |
| irq_out | output | 1 | Level interrupt request |

## Verification
The bench drives event pulses while sources are masked, which separates the raw view from the pending view. It then sets and clears the mask with data patterns that mix ones and zeros, which shows whether zero bits are really left alone. Status clears are done both one bit at a time and all at once, so a line that drops too early can be told apart from one that is held until the last enabled bit is cleared. Two further cases cover an event and an acknowledge landing on the same bit in the same cycle, and writes to the read-only or unmapped offsets. Those show whether priority and decode are correct rather than just the common path.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h2C;
  localparam int WORD_DONE_BIT = 1;

  typedef struct packed {
    logic raw;
    logic pend;
    logic en_set;
    logic en_clr;
  } sel_t;

  function automatic sel_t decode_addr(input logic [ADDR_W-1:0] a);
    sel_t s;
    s.raw    = (a == OFS_RAW);
    s.pend   = (a == OFS_PEND);
    s.en_set = (a == OFS_ENSET);
    s.en_clr = (a == OFS_ENCLR);
    return s;
  endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 8
) (
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output sel_t               sel,
  output logic [NUM_SRC-1:0] en_set_mask,
  output logic [NUM_SRC-1:0] en_clr_mask,
  output logic [NUM_SRC-1:0] pend_clr_mask,
  output logic               raw_wr
);
  logic [NUM_SRC-1:0] wbits;

  assign sel   = decode_addr(bus_addr);
  assign wbits = bus_wdata[NUM_SRC-1:0];

  always_comb begin
    en_set_mask   = (bus_wr && sel.en_set) ? wbits : '0;
    en_clr_mask   = (bus_wr && sel.en_clr) ? wbits : '0;
    pend_clr_mask = (bus_wr && sel.pend)   ? wbits : '0;
    raw_wr        = bus_wr && sel.raw;
  end

  generate
    if (DATA_W > NUM_SRC) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
    end
  endgenerate
endmodule

// File: rtl/irqc_enable.sv
module irqc_enable #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_mask,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] en_q
);
  function automatic logic [NUM_SRC-1:0] next_en(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] s,
    input logic [NUM_SRC-1:0] c);
    return (cur | s) & ~c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= next_en(en_q, set_mask, clr_mask);
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] raw_q
);
  function automatic logic next_bit(input logic cur, input logic evt, input logic clr);
    return evt | (cur & ~clr);
  endfunction

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) raw_q[i] <= 1'b0;
        else        raw_q[i] <= next_bit(raw_q[i], evt_in[i], clr_mask[i]);
      end
    end
  endgenerate
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic               irq_out
);
  sel_t               sel;
  logic [NUM_SRC-1:0] en_set_w, en_clr_w, pend_clr_w;
  logic               raw_wr_w;
  logic [NUM_SRC-1:0] raw_q, en_q, pend_w;

  irqc_decode #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .sel(sel), .en_set_mask(en_set_w), .en_clr_mask(en_clr_w),
    .pend_clr_mask(pend_clr_w), .raw_wr(raw_wr_w));

  irqc_enable #(.NUM_SRC(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .set_mask(en_set_w), .clr_mask(en_clr_w), .en_q(en_q));

  irqc_status #(.NUM_SRC(NUM_SRC)) u_st (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .clr_mask(pend_clr_w), .raw_q(raw_q));

  assign pend_w  = raw_q & en_q;
  assign irq_out = |pend_w;

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel.raw:                bus_rdata[NUM_SRC-1:0] = raw_q;
      sel.pend:               bus_rdata[NUM_SRC-1:0] = pend_w;
      sel.en_set, sel.en_clr: bus_rdata[NUM_SRC-1:0] = en_q;
      default:                bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_in,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] en_set_w,
  input logic [NUM_SRC-1:0] en_clr_w,
  input logic [NUM_SRC-1:0] pend_clr_w,
  input logic               raw_wr_w,
  input logic               irq_out
);
  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((raw_q & $past(evt_in)) == $past(evt_in))); // R2
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_set_w) |=> ((en_q & $past(en_set_w)) == $past(en_set_w))); // R4
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr_w) |=> ((en_q & $past(en_clr_w)) == '0)); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_w == '0 && en_clr_w == '0) |=> $stable(en_q)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_clr_w & ~evt_in)) |=> ((raw_q & $past(pend_clr_w & ~evt_in)) == '0)); // R5
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out); // R6
  AST_NO_RAW_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q == '0) |-> !irq_out); // R6
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_in & pend_clr_w)) |=> ((raw_q & $past(evt_in & pend_clr_w)) == $past(evt_in & pend_clr_w))); // R7
  AST_RAW_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_wr_w && evt_in == '0) |=> $stable(raw_q)); // R8
endmodule

bind irqc_top irqc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .raw_q(raw_q), .en_q(en_q),
  .en_set_w(en_set_w), .en_clr_w(en_clr_w), .pend_clr_w(pend_clr_w),
  .raw_wr_w(raw_wr_w), .irq_out(irq_out));

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int NUM_SRC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_SRC-1:0] evt_in = '0;
  logic irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [NUM_SRC-1:0] raw_m = '0;
  logic [NUM_SRC-1:0] en_m = '0;

  logic [7:0]        q_addr[$];
  logic [DATA_W-1:0] q_data[$];
  logic              q_irq[$];
  string             q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq_out(irq_out));

  // monitor: compares at the falling edge the item queued after the previous rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (q_addr.size() > 0) begin
        logic [7:0] a;
        logic [DATA_W-1:0] d;
        logic ei;
        string t;
        a = q_addr.pop_front(); d = q_data.pop_front();
        ei = q_irq.pop_front(); t = q_tag.pop_front();
        n_chk++;
        if (bus_rdata !== d || irq_out !== ei) begin
          n_fail++;
          $display("FAIL %s addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                   t, a, bus_rdata, irq_out, d, ei);
        end
      end
    end
  end

  function automatic logic [DATA_W-1:0] ext(input logic [NUM_SRC-1:0] v);
    return {{(DATA_W-NUM_SRC){1'b0}}, v};
  endfunction

  task automatic expect_rd(input logic [7:0] a, input logic [DATA_W-1:0] d, input string tag);
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = a;
    q_addr.push_back(a); q_data.push_back(d);
    q_irq.push_back(|(raw_m & en_m)); q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [NUM_SRC-1:0] d, input logic [NUM_SRC-1:0] ev);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = ext(d) | 32'hFF00_0000; evt_in = ev;
    @(posedge clk); #1;
    bus_wr = 1'b0; evt_in = '0;
    case (a)
      8'h24: raw_m = raw_m & ~d;
      8'h28: en_m  = en_m | d;
      8'h2C: en_m  = en_m & ~d;
      default: ;
    endcase
    raw_m = raw_m | ev;
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] ev);
    @(posedge clk); #1;
    evt_in = ev;
    @(posedge clk); #1;
    evt_in = '0;
    raw_m = raw_m | ev;
  endtask

  task automatic chk_all(input string tag);
    expect_rd(8'h20, ext(raw_m), tag);
    expect_rd(8'h24, ext(raw_m & en_m), tag);
    expect_rd(8'h28, ext(en_m), tag);
    expect_rd(8'h2C, ext(en_m), tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_all("R1 reset state");

    pulse(8'h02);
    chk_all("R2 R9 word-complete latched while masked, R3 pending zero");

    wr(8'h28, 8'h02, 8'h00);
    chk_all("R4 R9 enable set bit 1, R6 irq raised");

    wr(8'h28, 8'h00, 8'h00);
    wr(8'h2C, 8'h00, 8'h00);
    wr(8'h24, 8'h00, 8'h00);
    chk_all("R4 R5 zero writes have no effect");

    wr(8'h24, 8'h02, 8'h00);
    chk_all("R5 R9 acknowledge clears bit 1, R6 irq drops");

    pulse(8'h85);
    wr(8'h28, 8'h05, 8'h00);
    chk_all("R2 R4 several sources, R3 pending masked");

    wr(8'h24, 8'h01, 8'h00);
    chk_all("R6 irq held while bit 2 still pending");

    wr(8'h2C, 8'h04, 8'h00);
    chk_all("R4 R6 masking last pending bit drops irq");

    wr(8'h20, 8'hFF, 8'h00);
    expect_rd(8'h20, ext(raw_m), "R8 raw offset write ignored");
    expect_rd(8'h30, '0, "R8 unmapped offset reads zero");
    expect_rd(8'h00, '0, "R8 unmapped offset reads zero");

    wr(8'h28, 8'hFF, 8'h00);
    pulse(8'h10);
    wr(8'h24, 8'h11, 8'h10);
    chk_all("R7 event wins over same-cycle acknowledge");

    wr(8'h24, 8'hFF, 8'h00);
    chk_all("R5 R6 clear all, irq low");

    while (q_addr.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule